// File: doc/BRIEF.md
# Condition Check and Status Flag Unit

This block keeps the four status flags of an integer pipeline (negative, zero, carry, overflow) and decides, each cycle, whether the instruction in the execute stage may take effect. The instruction supplies a 4-bit condition code, a request to update the flags, and an operation class. In the same cycle the ALU supplies its result, carry-out, signed overflow and shifter carry-out. The block returns an execute enable and a separate result write enable, and it presents the flags it holds.

The condition is always judged against the flags that are registered at the start of the cycle. A flag update made by an instruction is registered at the clock edge that ends that instruction's cycle. The instruction in the next cycle is therefore the first to see it. Compare-type and test-type operations always update the flags and never write a result. Ordinary arithmetic and logical operations touch the flags only when they ask to. An instruction whose condition fails leaves no trace.

Top module: `cond_flag_unit`

## Requirements
- R1: While rst_ni is low, flags_o reads 4'b0000. The flag bits are ordered {N, Z, C, V}, with N at bit 3 and V at bit 0.
- R2: When valid_i is high, exec_o is high exactly when cond_i passes against the registered flags, using this encoding:
  - 0000: Z set.
  - 0001: Z clear.
  - 0010: C set.
  - 0011: C clear.
  - 0100: N set.
  - 0101: N clear.
  - 0110: V set.
  - 0111: V clear.
  - 1000: C set and Z clear.
  - 1001: C clear or Z set.
  - 1010: N equals V.
  - 1011: N differs from V.
  - 1100: Z clear and N equals V.
  - 1101: Z set or N differs from V.
  - 1110: always passes.
  - 1111: never passes.
- R3: When op_class_i is arithmetic (2'b00) or logical (2'b01) and set_flags_i is low, the flags do not change.
- R4: An executing arithmetic operation (2'b00) with set_flags_i high loads the following values, visible after the next rising edge:
  - N from result_i bit 31.
  - Z set exactly when result_i is zero.
  - C from carry_i.
  - V from overflow_i.
- R5: An executing logical operation (2'b01) with set_flags_i high loads N and Z as in R4 and takes C from shift_carry_i. V is kept.
- R6: An executing compare operation (2'b10) updates the flags as in R4, and an executing test operation (2'b11) updates them as in R5. Both do so whatever the value of set_flags_i, and for both wr_result_o stays low.
- R7: When valid_i is low or the condition fails, exec_o and wr_result_o are low and the flags do not change.
- R8: exec_o in a cycle depends on the flags registered before that cycle. An update made in that same cycle affects only the next cycle's decision.
- R9: For an executing arithmetic or logical operation, wr_result_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is present this cycle |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Flag update request |
| op_class_i | input | 2 | 00 arithmetic, 01 logical, 10 compare, 11 test |
| result_i | input | 32 | ALU result |
| carry_i | input | 1 | Adder carry-out |
| overflow_i | input | 1 | Adder signed overflow |
| shift_carry_i | input | 1 | Shifter carry-out |
| exec_o | output | 1 | Instruction may take effect |
| wr_result_o | output | 1 | Result may be written |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
Two things can happen in the same cycle: the condition decision and a flag write. An instruction that sets flags can itself be conditional, so its pass or fail is judged on the old flags while it is producing new ones. The bench provokes this with long random runs in which set_flags_i, compare and test classes, and conditions are mixed back to back. It adds directed pairs, such as a zero-producing compare followed by an equal or not-equal test. Each cycle the bench judges exec_o against a model holding the flags from before the edge, and it judges flags_o one edge later against the model updated only when the instruction executed.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [1:0] {
    OP_ARITH = 2'b00,
    OP_LOGIC = 2'b01,
    OP_CMP   = 2'b10,
    OP_TST   = 2'b11
  } op_class_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;
endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic nv_eq;
  assign nv_eq = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_CS:   pass_o = flags_i.c;
      CC_CC:   pass_o = !flags_i.c;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = !flags_i.v;
      CC_HI:   pass_o = flags_i.c & !flags_i.z;
      CC_LS:   pass_o = !flags_i.c | flags_i.z;
      CC_GE:   pass_o = nv_eq;
      CC_LT:   pass_o = !nv_eq;
      CC_GT:   pass_o = !flags_i.z & nv_eq;
      CC_LE:   pass_o = flags_i.z | !nv_eq;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        op_class_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              overflow_i,
  input  logic              shift_carry_i,
  input  flags_t            cur_i,
  output flags_t            next_o
);
  localparam int MSB = DATA_W - 1;

  // bit 0 of the class selects logical semantics (logic/test)
  logic logical;
  assign logical = op_class_i[0];

  always_comb begin
    next_o.n = result_i[MSB];
    next_o.z = (result_i == '0);
    next_o.c = logical ? shift_carry_i : carry_i;
    next_o.v = logical ? cur_i.v : overflow_i;
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        cond_i,
  input  logic              set_flags_i,
  input  logic [1:0]        op_class_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              overflow_i,
  input  logic              shift_carry_i,
  output logic              exec_o,
  output logic              wr_result_o,
  output logic [3:0]        flags_o
);
  flags_t flags_q, flags_d;
  logic   pass, is_cmp, upd;

  cfu_cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (pass)
  );

  cfu_flag_next #(.DATA_W(DATA_W)) u_next (
    .op_class_i    (op_class_i),
    .result_i      (result_i),
    .carry_i       (carry_i),
    .overflow_i    (overflow_i),
    .shift_carry_i (shift_carry_i),
    .cur_i         (flags_q),
    .next_o        (flags_d)
  );

  assign is_cmp      = op_class_i[1];
  assign exec_o      = valid_i & pass;
  assign wr_result_o = exec_o & !is_cmp;
  assign upd         = exec_o & (set_flags_i | is_cmp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        cond_i,
  input logic              set_flags_i,
  input logic [1:0]        op_class_i,
  input logic [DATA_W-1:0] result_i,
  input logic              carry_i,
  input logic              overflow_i,
  input logic              shift_carry_i,
  input logic              exec_o,
  input logic              wr_result_o,
  input logic [3:0]        flags_o
);
  localparam int MSB = DATA_W - 1;

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (flags_o == 4'b0000);

  assert_always_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'hE) |-> exec_o);
  assert_never_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hF) |-> !exec_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && !op_class_i[1]) |=> $stable(flags_o));
  assert_arith_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && set_flags_i && op_class_i == 2'b00) |=>
      flags_o == {$past(result_i[MSB]), $past(result_i == '0), $past(carry_i), $past(overflow_i)});
  assert_logic_v_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && set_flags_i && op_class_i == 2'b01) |=> flags_o[0] == $past(flags_o[0]));
  assert_cmp_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_class_i[1] |-> !wr_result_o);
  assert_fail_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |=> $stable(flags_o));
  assert_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !op_class_i[1]) |-> wr_result_o);
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .cond_i        (cond_i),
  .set_flags_i   (set_flags_i),
  .op_class_i    (op_class_i),
  .result_i      (result_i),
  .carry_i       (carry_i),
  .overflow_i    (overflow_i),
  .shift_carry_i (shift_carry_i),
  .exec_o        (exec_o),
  .wr_result_o   (wr_result_o),
  .flags_o       (flags_o)
);

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  cond_i = 4'hE;
  logic        set_flags_i = 1'b0;
  logic [1:0]  op_class_i = 2'b00;
  logic [31:0] result_i = '0;
  logic        carry_i = 1'b0, overflow_i = 1'b0, shift_carry_i = 1'b0;
  logic        exec_o, wr_result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model = 4'b0000; // {N,Z,C,V}

  always #4 clk_i = ~clk_i; // 125 MHz

  cond_flag_unit dut (.*);

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy && !z;   4'h9: return !cy || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && n == v;
      4'hD: return z || n != v;
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one instruction: drive at negedge, judge decision, then judge flags one edge later
  task automatic issue(input logic vld, input logic [3:0] c, input logic sf,
                       input logic [1:0] cls, input logic [31:0] res,
                       input logic cy, input logic ov, input logic sc);
    logic ex, upd;
    logic [3:0] nxt;
    @(negedge clk_i);
    valid_i = vld; cond_i = c; set_flags_i = sf; op_class_i = cls;
    result_i = res; carry_i = cy; overflow_i = ov; shift_carry_i = sc;
    #1;
    ex = vld && cond_ok(c, model); // R8: decided on old flags
    check(vld ? "R2/R8 exec" : "R7 exec idle", {31'b0, exec_o}, {31'b0, ex});
    check(cls[1] ? "R6 no write" : (ex ? "R9 write" : "R7 no write"),
          {31'b0, wr_result_o}, {31'b0, ex && !cls[1]});
    upd = ex && (sf || cls[1]);
    nxt = model;
    if (upd) begin
      nxt[3] = res[31];
      nxt[2] = (res == 32'b0);
      nxt[1] = cls[0] ? sc : cy;
      nxt[0] = cls[0] ? model[0] : ov;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (!ex)            check("R7 flags kept", {28'b0, flags_o}, {28'b0, nxt});
    else if (cls[1])    check("R6 cmp/test flags", {28'b0, flags_o}, {28'b0, nxt});
    else if (!sf)       check("R3 flags kept", {28'b0, flags_o}, {28'b0, nxt});
    else if (cls == 2'b00) check("R4 arith flags", {28'b0, flags_o}, {28'b0, nxt});
    else                check("R5 logic flags", {28'b0, flags_o}, {28'b0, nxt});
    model = nxt;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #3;
    check("R1 reset flags", {28'b0, flags_o}, 32'h0);
    @(negedge clk_i);
    check("R1 reset flags held", {28'b0, flags_o}, 32'h0);
    rst_ni = 1'b1;

    // directed corners
    issue(1, 4'hE, 1, 2'b00, 32'h8000_0000, 1, 1, 0); // R4: N,C,V set
    issue(1, 4'hB, 0, 2'b00, 32'h1, 0, 0, 0);         // LT false: N==V -> R7
    issue(1, 4'hE, 0, 2'b10, 32'h0, 1, 0, 0);         // R6 compare without S -> Z,C
    issue(1, 4'h0, 1, 2'b01, 32'h5, 0, 1, 1);         // EQ passes on old flags (R8), logic keeps V (R5)
    issue(1, 4'h0, 1, 2'b00, 32'h0, 0, 0, 0);         // EQ now fails -> R7
    issue(1, 4'hF, 1, 2'b11, 32'h0, 1, 1, 1);         // never -> R2, no effect
    issue(1, 4'hE, 0, 2'b11, 32'hFFFF_FFFF, 1, 1, 1); // R6 test path: V kept
    issue(1, 4'hE, 1, 2'b01, 32'h0, 0, 1, 0);         // R5
    issue(0, 4'hE, 1, 2'b10, 32'h8000_0000, 1, 1, 1); // R7 idle
    issue(1, 4'hE, 0, 2'b00, 32'h0, 1, 1, 1);         // R3 no S

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if ($urandom_range(3) == 0) r = 32'h0;
      issue($urandom_range(7) != 0, 4'($urandom), 1'($urandom), 2'($urandom), r,
            1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule